// File: doc/BRIEF.md
# Floating-Point to Integer Converter

This block turns an operand that has already been unpacked from its floating-point encoding into a signed two's-complement integer of parameterised width (32 or 64 bits). The operand arrives as a sign, a 3-bit class code, a signed unbiased exponent, a normalised mantissa and a sticky bit. The mantissa has its leading one in the MSB, so the operand value is `mant_i * 2^(exp_i - (MW-1))`. Rounding follows one of four IEEE-style directions, selected by a mode input. A truncate input forces round-toward-zero for truncating conversion instructions.

Values that do not fit saturate. Saturation is asymmetric, so the most negative integer is still a legal result. Every NaN maps to the negative saturation value. Whenever saturation happens, the rounding flags are dropped and only the invalid-conversion flag remains. The flags are inexact, fraction-rounded, invalid-conversion and invalid-signalling-NaN.

The block accepts an operand on a valid/ready handshake. It presents the integer and the flags from an output register one cycle after acceptance and holds them until they are taken.

Top module: `fp2int_conv`

## Requirements
- R1: Class code 0 (zero) gives result 0 with all four flags clear.
- R2: Class code 2 (infinity), or class code 1 (number) with `exp_i >= IW`, saturates. A positive sign gives 2^(IW-1)-1 and a negative sign gives -2^(IW-1). Invalid-conversion is set; inexact and fraction-rounded are clear.
- R3: Class code 4 (signalling NaN), class code 3 (quiet NaN) and the unused codes 5 to 7 all give -2^(IW-1) with invalid-conversion set, whatever the sign. Only code 4 also sets the invalid-signalling-NaN flag.
- R4: A number with no nonzero bits below the integer LSB and `sticky_i` low gives the exact integer (negated in two's complement when the sign is set) with no flags. This holds for any exponent below `IW`, including negative exponents.
- R5: If any bit below the integer LSB or `sticky_i` is nonzero, and the result does not saturate, inexact is set.
- R6: Mode 00 (nearest-even) adds one to the magnitude when the first bit below the LSB is set and either a lower discarded bit, `sticky_i` or the magnitude LSB is set.
- R7: Mode 01 never adds one. Mode 10 adds one to an inexact magnitude only for a positive sign. Mode 11 adds one to an inexact magnitude only for a negative sign.
- R8: Fraction-rounded is set exactly when the magnitude was incremented and the result does not saturate.
- R9: After rounding, a magnitude of at least 2^(IW-1) plus the sign bit saturates as in R2, with inexact and fraction-rounded cleared. A negative magnitude of exactly 2^(IW-1) gives -2^(IW-1) with no invalid flag.
- R10: When `trunc_i` is high, rounding is round-toward-zero regardless of `rmode_i`.
- R11: `ready_o` is high when the output register is empty or `ready_i` is high. An operand accepted at a clock edge appears on `result_o` and the flags with `valid_o` high after that edge. While `valid_o` is high and `ready_i` is low, the outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand present |
| ready_o | output | 1 | Converter can accept an operand |
| sign_i | input | 1 | Operand sign, 1 = negative |
| class_i | input | 3 | 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| exp_i | input | EW | Signed unbiased exponent |
| mant_i | input | MW | Normalised mantissa, leading one in MSB |
| sticky_i | input | 1 | OR of mantissa bits lost before this block |
| rmode_i | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| trunc_i | input | 1 | Force round-toward-zero |
| valid_o | output | 1 | Result present |
| ready_i | input | 1 | Consumer takes the result |
| result_o | output | IW | Signed integer result |
| inexact_o | output | 1 | Result differs from operand |
| rounded_o | output | 1 | Magnitude was incremented |
| invalid_o | output | 1 | Conversion saturated or operand was NaN |
| snan_o | output | 1 | Operand was a signalling NaN |

## Verification
All of the logic is combinational in front of one register, so any internal fault shows at the ports in the very cycle after the operand is accepted. A wrong shift stage or a lost guard/sticky bit shows as a result off by one, or off by a power of two, together with a wrong inexact or rounded flag. A wrong overflow limit shows at the boundary values around 2^(IW-1), where the sign decides between a legal minimum integer and saturation. A fault in the hold logic shows as result or flag changes while the consumer stalls.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;

  localparam logic [2:0] CLS_ZERO = 3'd0;
  localparam logic [2:0] CLS_NUM  = 3'd1;
  localparam logic [2:0] CLS_INF  = 3'd2;
  localparam logic [2:0] CLS_QNAN = 3'd3;
  localparam logic [2:0] CLS_SNAN = 3'd4;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_PINF = 2'b10,
    RM_NINF = 2'b11
  } rmode_e;

  typedef struct packed {
    logic snan;
    logic invalid;
    logic rounded;
    logic inexact;
  } cvt_flags_t;

endpackage

// File: rtl/fp2int_align.sv
module fp2int_align #(
  parameter int IW = 32,
  parameter int MW = 53,
  parameter int EW = 12
) (
  input  logic [EW-1:0] exp_i,
  input  logic [MW-1:0] mant_i,
  input  logic          sticky_i,
  output logic [IW-1:0] mag_o,
  output logic          guard_o,
  output logic          rest_o,
  output logic          big_o
);
  localparam int F  = MW - 1;
  localparam int AW = IW + MW;
  localparam int SW = $clog2(IW);

  logic          neg_exp;
  logic          exp_m1;
  logic [AW-1:0] stg [SW+1];

  assign neg_exp = exp_i[EW-1];
  assign exp_m1  = &exp_i;
  assign big_o   = !neg_exp && (exp_i >= EW'(IW));

  // log shifter: integer part lands in bits [F+IW-1:F]
  assign stg[0] = {{IW{1'b0}}, mant_i};
  for (genvar k = 0; k < SW; k++) begin : g_shift
    assign stg[k+1] = exp_i[k] ? (stg[k] << (2**k)) : stg[k];
  end

  always_comb begin
    if (neg_exp) begin
      mag_o   = '0;
      guard_o = exp_m1;
      rest_o  = exp_m1 ? (|mant_i[MW-2:0] | sticky_i) : 1'b1;
    end else begin
      mag_o   = stg[SW][F+IW-1:F];
      guard_o = stg[SW][F-1];
      rest_o  = |stg[SW][F-2:0] | sticky_i;
    end
  end

endmodule

// File: rtl/fp2int_round.sv
module fp2int_round
  import fp2int_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic [IW-1:0] mag_i,
  input  logic          guard_i,
  input  logic          rest_i,
  input  logic          sign_i,
  input  rmode_e        mode_i,
  output logic [IW:0]   mag_o,
  output logic          inexact_o,
  output logic          inc_o
);
  assign inexact_o = guard_i | rest_i;

  always_comb begin
    unique case (mode_i)
      RM_NEAR: inc_o = guard_i & (rest_i | mag_i[0]);
      RM_ZERO: inc_o = 1'b0;
      RM_PINF: inc_o = !sign_i & inexact_o;
      RM_NINF: inc_o = sign_i & inexact_o;
      default: inc_o = 1'b0;
    endcase
  end

  assign mag_o = {1'b0, mag_i} + (IW+1)'(inc_o);

endmodule

// File: rtl/fp2int_pack.sv
module fp2int_pack
  import fp2int_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic [2:0]    cls_i,
  input  logic          sign_i,
  input  logic          big_i,
  input  logic [IW:0]   mag_i,
  input  logic          inexact_i,
  input  logic          inc_i,
  output logic [IW-1:0] result_o,
  output cvt_flags_t    flags_o
);
  localparam logic [IW-1:0] MAX_POS = {1'b0, {(IW-1){1'b1}}};
  localparam logic [IW-1:0] MIN_NEG = {1'b1, {(IW-1){1'b0}}};

  logic [IW:0]   limit;
  logic          ovf;
  logic [IW-1:0] sat_val;

  assign limit   = {1'b0, MIN_NEG} + (IW+1)'(sign_i);
  assign ovf     = big_i || (mag_i >= limit);
  assign sat_val = sign_i ? MIN_NEG : MAX_POS;

  always_comb begin
    result_o = '0;
    flags_o  = '0;
    case (cls_i)
      CLS_ZERO: ;
      CLS_NUM: begin
        if (ovf) begin
          result_o        = sat_val;
          flags_o.invalid = 1'b1;
        end else begin
          result_o        = sign_i ? (~mag_i[IW-1:0] + 1'b1) : mag_i[IW-1:0];
          flags_o.inexact = inexact_i;
          flags_o.rounded = inc_i;
        end
      end
      CLS_INF: begin
        result_o        = sat_val;
        flags_o.invalid = 1'b1;
      end
      CLS_SNAN: begin
        result_o        = MIN_NEG;
        flags_o.invalid = 1'b1;
        flags_o.snan    = 1'b1;
      end
      default: begin
        result_o        = MIN_NEG;
        flags_o.invalid = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/fp2int_conv.sv
module fp2int_conv
  import fp2int_pkg::*;
#(
  parameter int IW = 32,
  parameter int MW = 53,
  parameter int EW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  output logic          ready_o,
  input  logic          sign_i,
  input  logic [2:0]    class_i,
  input  logic [EW-1:0] exp_i,
  input  logic [MW-1:0] mant_i,
  input  logic          sticky_i,
  input  logic [1:0]    rmode_i,
  input  logic          trunc_i,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [IW-1:0] result_o,
  output logic          inexact_o,
  output logic          rounded_o,
  output logic          invalid_o,
  output logic          snan_o
);
  localparam logic [IW-1:0] MAX_POS = {1'b0, {(IW-1){1'b1}}};
  localparam logic [IW-1:0] MIN_NEG = {1'b1, {(IW-1){1'b0}}};

  rmode_e        mode;
  logic [IW-1:0] al_mag;
  logic          al_guard, al_rest, al_big;
  logic [IW:0]   rn_mag;
  logic          rn_inexact, rn_inc;
  logic [IW-1:0] pk_result;
  cvt_flags_t    pk_flags;
  logic          accept;
  logic [IW-1:0] result_q;
  cvt_flags_t    flags_q;
  logic          valid_q;

  assign mode = trunc_i ? RM_ZERO : rmode_e'(rmode_i);

  fp2int_align #(.IW(IW), .MW(MW), .EW(EW)) align_i (
    .exp_i    (exp_i),
    .mant_i   (mant_i),
    .sticky_i (sticky_i),
    .mag_o    (al_mag),
    .guard_o  (al_guard),
    .rest_o   (al_rest),
    .big_o    (al_big)
  );

  fp2int_round #(.IW(IW)) round_i (
    .mag_i     (al_mag),
    .guard_i   (al_guard),
    .rest_i    (al_rest),
    .sign_i    (sign_i),
    .mode_i    (mode),
    .mag_o     (rn_mag),
    .inexact_o (rn_inexact),
    .inc_o     (rn_inc)
  );

  fp2int_pack #(.IW(IW)) pack_i (
    .cls_i     (class_i),
    .sign_i    (sign_i),
    .big_i     (al_big),
    .mag_i     (rn_mag),
    .inexact_i (rn_inexact),
    .inc_i     (rn_inc),
    .result_o  (pk_result),
    .flags_o   (pk_flags)
  );

  assign ready_o = !valid_q || ready_i;
  assign accept  = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      flags_q  <= '0;
    end else begin
      if (accept) begin
        valid_q  <= 1'b1;
        result_q <= pk_result;
        flags_q  <= pk_flags;
      end else if (ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o   = valid_q;
  assign result_o  = result_q;
  assign inexact_o = flags_q.inexact;
  assign rounded_o = flags_q.rounded;
  assign invalid_o = flags_q.invalid;
  assign snan_o    = flags_q.snan;

  assert_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && class_i == CLS_ZERO |=> result_o == '0 && !inexact_o && !rounded_o && !invalid_o && !snan_o);

  assert_sat_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && invalid_o |-> result_o == MAX_POS || result_o == MIN_NEG);

  assert_snan_inv_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && snan_o |-> invalid_o && result_o == MIN_NEG);

  assert_rnd_inexact_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && rounded_o |-> inexact_o);

  assert_no_round_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && invalid_o |-> !inexact_o && !rounded_o);

  assert_trunc_no_inc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && trunc_i |=> !rounded_o);

  assert_accept_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> valid_o);

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(result_o) && $stable(flags_q));

endmodule

// File: tb/fp2int_conv_tb_top.sv
`timescale 1ns/1ps
module fp2int_conv_tb_top;
  localparam int IW = 32;
  localparam int MW = 53;
  localparam int EW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0, ready_i = 1'b1;
  logic          sign_i = 1'b0, sticky_i = 1'b0, trunc_i = 1'b0;
  logic [2:0]    class_i = '0;
  logic [EW-1:0] exp_i = '0;
  logic [MW-1:0] mant_i = '0;
  logic [1:0]    rmode_i = '0;
  logic          ready_o, valid_o;
  logic [IW-1:0] result_o;
  logic          inexact_o, rounded_o, invalid_o, snan_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fp2int_conv #(.IW(IW), .MW(MW), .EW(EW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .ready_o(ready_o),
    .sign_i(sign_i), .class_i(class_i), .exp_i(exp_i), .mant_i(mant_i),
    .sticky_i(sticky_i), .rmode_i(rmode_i), .trunc_i(trunc_i),
    .valid_o(valid_o), .ready_i(ready_i), .result_o(result_o),
    .inexact_o(inexact_o), .rounded_o(rounded_o), .invalid_o(invalid_o), .snan_o(snan_o)
  );

  // returns {snan, invalid, rounded, inexact, result}
  function automatic logic [35:0] ref_conv(input logic s, input logic [2:0] c, input int e,
                                           input logic [52:0] m, input logic st,
                                           input logic [1:0] rm, input logic tr);
    logic [191:0] v, w;
    logic [63:0]  ip;
    logic [64:0]  mag;
    logic         g, rest, inc, lost;
    logic [1:0]   md;
    logic [31:0]  sat;
    int           sh;
    sat = s ? 32'h8000_0000 : 32'h7FFF_FFFF;
    if (c == 3'd0) return 36'h0;
    if (c == 3'd2) return {4'b0100, sat};
    if (c == 3'd4) return {4'b1100, 32'h8000_0000};
    if (c != 3'd1) return {4'b0100, 32'h8000_0000};
    if (e >= 32) return {4'b0100, sat};
    sh = 52 - e;
    v  = {75'b0, m, 64'b0};
    if (sh > 180) begin
      ip = '0; g = 1'b0; rest = 1'b1;
    end else begin
      w    = v >> sh;
      lost = ((w << sh) != v);
      ip   = w[127:64];
      g    = w[63];
      rest = (|w[62:0]) | lost | st;
    end
    md = tr ? 2'b01 : rm;
    case (md)
      2'b00:   inc = g & (rest | ip[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = !s & (g | rest);
      default: inc = s & (g | rest);
    endcase
    mag = {1'b0, ip} + 65'(inc);
    if (mag >= 65'h8000_0000 + 65'(s)) return {4'b0100, sat};
    return {2'b00, inc, g | rest, s ? (~mag[31:0] + 32'd1) : mag[31:0]};
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got res=%h flags=%b expected res=%h flags=%b",
               tag, act[31:0], act[35:32], exp[31:0], exp[35:32]);
    end
  endtask

  function automatic logic [35:0] outs();
    return {snan_o, invalid_o, rounded_o, inexact_o, result_o};
  endfunction

  task automatic send(input logic s, input logic [2:0] c, input int e, input logic [52:0] m,
                      input logic st, input logic [1:0] rm, input logic tr,
                      input bit stall, input string tag);
    logic [35:0] exp_v, held;
    exp_v = ref_conv(s, c, e, m, st, rm, tr);
    @(negedge clk);
    sign_i = s; class_i = c; exp_i = EW'(e); mant_i = m; sticky_i = st;
    rmode_i = rm; trunc_i = tr; valid_i = 1'b1; ready_i = !stall;
    @(negedge clk);
    valid_i = 1'b0;
    check({tag, " R11 valid"}, {35'b0, valid_o}, 36'd1);
    check(tag, outs(), exp_v);
    if (stall) begin
      held = outs();
      check("R11 ready low while full", {35'b0, ready_o}, 36'd0);
      @(negedge clk);
      check("R11 held", outs(), held);
      ready_i = 1'b1;
      @(negedge clk);
      check("R11 drained", {35'b0, valid_o}, 36'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [52:0] m;
    int          e;
    logic [2:0]  c;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("reset valid_o", {35'b0, valid_o}, 36'd0);
    check("reset ready_o", {35'b0, ready_o}, 36'd1);
    rst_n = 1'b1;

    send(0, 3'd0, 7, {1'b1, 52'b0}, 0, 2'b10, 0, 0, "R1 zero");
    send(1, 3'd0, 0, {1'b1, 52'b0}, 1, 2'b11, 0, 0, "R1 neg zero");
    send(0, 3'd2, 0, {1'b1, 52'b0}, 0, 2'b00, 0, 0, "R2 +inf");
    send(1, 3'd2, 0, {1'b1, 52'b0}, 0, 2'b00, 0, 0, "R2 -inf");
    send(0, 3'd1, 32, {1'b1, 52'b0}, 0, 2'b00, 0, 0, "R2 exp=IW pos");
    send(1, 3'd1, 40, {1'b1, 52'b0}, 1, 2'b00, 0, 0, "R2 exp big neg");
    send(0, 3'd3, 0, {1'b1, 52'b0}, 0, 2'b00, 0, 0, "R3 qnan");
    send(0, 3'd4, 0, {1'b1, 52'b0}, 0, 2'b00, 0, 0, "R3 snan");
    send(1, 3'd6, 0, {1'b1, 52'b0}, 0, 2'b00, 0, 0, "R3 unused code");
    send(0, 3'd1, 2, {3'b101, 50'b0}, 0, 2'b00, 0, 0, "R4 +5 exact");
    send(1, 3'd1, 2, {3'b101, 50'b0}, 0, 2'b10, 0, 0, "R4 -5 exact");
    send(0, 3'd1, 2, {3'b101, 50'b0}, 1, 2'b00, 0, 0, "R5 sticky only");
    send(0, 3'd1, -5, {1'b1, 52'b0}, 0, 2'b10, 0, 0, "R5 tiny +inf mode");
    send(0, 3'd1, 1, {3'b101, 50'b0}, 0, 2'b00, 0, 0, "R6 2.5 to even");
    send(0, 3'd1, 1, {3'b111, 50'b0}, 0, 2'b00, 0, 0, "R6 3.5 to even");
    send(0, 3'd1, -1, {1'b1, 52'b0}, 0, 2'b00, 0, 0, "R6 0.5 to even");
    send(0, 3'd1, -1, {2'b11, 51'b0}, 0, 2'b00, 0, 0, "R6 0.75 up");
    send(0, 3'd1, 1, {3'b101, 50'b0}, 0, 2'b01, 0, 0, "R7 toward zero");
    send(0, 3'd1, 1, {3'b101, 50'b0}, 0, 2'b10, 0, 0, "R7 +inf pos");
    send(1, 3'd1, 1, {3'b101, 50'b0}, 0, 2'b10, 0, 0, "R7 +inf neg");
    send(1, 3'd1, 1, {3'b101, 50'b0}, 0, 2'b11, 0, 0, "R7 -inf neg");
    send(0, 3'd1, 1, {3'b111, 50'b0}, 0, 2'b10, 0, 0, "R8 rounded flag");
    send(0, 3'd1, 31, {1'b1, 52'b0}, 0, 2'b00, 0, 0, "R9 +2^31 ovf");
    send(1, 3'd1, 31, {1'b1, 52'b0}, 0, 2'b00, 0, 0, "R9 -2^31 legal");
    send(0, 3'd1, 30, {32'hFFFF_FFFF, 21'b0}, 0, 2'b00, 0, 0, "R9 round into ovf");
    send(0, 3'd1, 30, {32'hFFFF_FFFF, 21'b0}, 0, 2'b01, 0, 0, "R9 no ovf toward zero");
    send(1, 3'd1, 30, {32'hFFFF_FFFF, 21'b0}, 0, 2'b11, 0, 0, "R9 neg round to min");
    send(0, 3'd1, 1, {3'b111, 50'b0}, 0, 2'b00, 1, 0, "R10 trunc over nearest");
    send(1, 3'd1, 1, {3'b111, 50'b0}, 0, 2'b11, 1, 0, "R10 trunc over -inf");
    send(1, 3'd1, 3, {3'b111, 50'b0}, 1, 2'b11, 0, 1, "R11 stall");
    send(0, 3'd4, 0, {1'b1, 52'b0}, 0, 2'b00, 0, 1, "R11 stall snan");

    for (int i = 0; i < 4000; i++) begin
      m = {1'b1, 20'($urandom), $urandom};
      if ($urandom_range(0, 3) == 0) m[40:0] = '0;
      e = $urandom_range(0, 39) - 4;
      if ($urandom_range(0, 19) == 0) e = -($urandom_range(5, 300));
      c = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(0, 7)) : 3'd1;
      send($urandom_range(0, 1), c, e, m, $urandom_range(0, 7) == 0,
           2'($urandom_range(0, 3)), $urandom_range(0, 5) == 0,
           $urandom_range(0, 15) == 0, "random");
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule